// File: doc/BRIEF.md
# GPIO Interrupt Detect Controller

This block watches 32 general-purpose input pins and turns their activity into interrupt requests. The pins form two banks of sixteen: pins 0 to 15 are the low bank and pins 16 to 31 are the high bank. Software configures the pins through 16-bit registers. Each function has one word per bank.

Each pin is configured independently. It can use level or edge detection. In level mode it has an active polarity. In edge mode it has separate rising and falling enables, and the event is either held until software clears it or passed through for one cycle. Each pin has a pending flag and an enable bit. Pending flags are cleared by writing a 1 to them.

The block drives one combined interrupt line and the 5-bit number of the winning pin. The low bank always wins over the high bank. Pin inputs pass through a two-flop synchroniser before any detection.

Top module: `gpio_irq_detect`

## Requirements
- R1: The 16-bit registers sit at these byte addresses, low-bank word first and high-bank word second: pending 0x08/0x0A, enable 0x0C/0x0E, mode 0x10/0x12, polarity 0x14/0x16, hold 0x18/0x1A, falling-edge select 0x20/0x22, rising-edge select 0x24/0x26. Bit n of a low word belongs to pin n, and bit n of a high word belongs to pin 16+n. A configuration word reads back the value written to it. Any other address reads 0.
- R2: After reset, every configuration bit and every pending flag is 0, irq_o is low and irq_id_o is 0.
- R3: A pin change that is set up before clock edge k shows in the pending flags and the outputs after edge k+2.
- R4: A pin whose mode bit is 0 is level sensitive. Its pending flag is 1 while the synchronised pin equals its polarity bit (1 means active high, 0 means active low), and 0 otherwise. A write-one-to-clear has no lasting effect on it.
- R5: A pin whose mode bit is 1 is edge sensitive. A 0-to-1 change is an event when its rising-select bit is 1, and a 1-to-0 change is an event when its falling-select bit is 1. With both bits set, both edges are events. The polarity bit has no effect on edge pins.
- R6: On an edge pin whose hold bit is 1, an event sets the pending flag. The flag stays set until a 1 is written to its bit of the pending word. Writing 0 bits leaves the flags unchanged.
- R7: On an edge pin whose hold bit is 0, the pending flag is 1 for exactly the one cycle that follows the event and is 0 afterwards.
- R8: If an event and a write-one-to-clear reach the same held flag in the same cycle, the flag ends up set.
- R9: irq_o is high exactly when some pin has both its pending flag and its enable bit at 1.
- R10: irq_id_o gives the lowest-numbered pin among the enabled pending pins of the low bank. If the low bank has none, it gives the lowest-numbered such pin of the high bank. It is 0 when irq_o is low.
- R11: Reading a pending word returns the current pending flags, whether or not the pins are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| bus_we_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr_i | input | 6 | Byte address of the 16-bit word |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |
| irq_id_o | output | 5 | Number of the winning pin |

## Verification
A wrong bit in the synchroniser or in the pending flags shows on irq_o, on irq_id_o and on the pending read word two edges after the pin stimulus. The bench compares all three on every cycle against its own model of the pin history, so a stuck or dropped flag is reported at that cycle. The bench places the bus address on a pending word whenever edges are being tested, so flags of pins that are not enabled are still seen through the read path. A fault in the priority logic shows up in the cycles where pins of both banks, or several pins of one bank, are pending together.

// File: rtl/gidc_pkg.sv
package gidc_pkg;
    localparam int NPINS  = 32;
    localparam int BANK_W = 16;
    localparam int NBANKS = NPINS / BANK_W;
    localparam int ID_W   = $clog2(NPINS);
    localparam int BIDX_W = $clog2(BANK_W);
    localparam int AW     = 6;
    localparam int DW     = BANK_W;

    // word base addresses (low bank); high bank sits at base + 2
    localparam logic [AW-1:0] A_PEND = 6'h08;
    localparam logic [AW-1:0] A_EN   = 6'h0C;
    localparam logic [AW-1:0] A_MODE = 6'h10;
    localparam logic [AW-1:0] A_POL  = 6'h14;
    localparam logic [AW-1:0] A_HOLD = 6'h18;
    localparam logic [AW-1:0] A_FSEL = 6'h20;
    localparam logic [AW-1:0] A_RSEL = 6'h24;

    typedef struct packed {
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] hold;
        logic [NPINS-1:0] fsel;
        logic [NPINS-1:0] rsel;
    } cfg_t;
endpackage

// File: rtl/gidc_sync.sv
module gidc_sync #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] old;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1  = d_i;
        sy_d.s2  = sy_q.s1;
        sy_d.old = sy_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sy_q <= '0;
        else         sy_q <= sy_d;
    end

    assign cur_o  = sy_q.s2;
    assign prev_o = sy_q.old;
endmodule

// File: rtl/gidc_detect.sv
module gidc_detect #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] mode_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] hold_i,
    input  logic [W-1:0] fsel_i,
    input  logic [W-1:0] rsel_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] pend_d, pend_q;
    logic [W-1:0] evt;

    always_comb begin
        evt    = mode_i & ((cur_i & ~prev_i & rsel_i) | (~cur_i & prev_i & fsel_i));
        pend_d = (mode_i &  hold_i & ((pend_q & ~clr_i) | evt))
               | (mode_i & ~hold_i & evt)
               | (~mode_i & ~(cur_i ^ pol_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R6: a held flag not written with 1 stays set
    p_hold_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(pend_q & mode_i & hold_i & ~clr_i) & ~pend_q) == '0));

    // R8: a selected edge on a held pin sets the flag even under a clear
    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(mode_i & hold_i &
                  ((cur_i & ~prev_i & rsel_i) | (~cur_i & prev_i & fsel_i))) & ~pend_q) == '0));

    // R4: level pins follow the synchronised pin compared with polarity
    p_level_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(~mode_i) & (pend_q ^ $past(~(cur_i ^ pol_i)))) == '0));
endmodule

// File: rtl/gidc_prio.sv
module gidc_prio #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [W-1:0]  req_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        hit_o = |req_i;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

    // R10: the reported index points at a requesting bit, else is zero
    p_idx_hits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> req_i[idx_o]);
    p_idx_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_o |-> (idx_o == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gidc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NPINS-1:0]    pin_i,
    input  logic                bus_we_i,
    input  logic [AW-1:0]       bus_addr_i,
    input  logic [DW-1:0]       bus_wdata_i,
    output logic [DW-1:0]       bus_rdata_o,
    output logic                irq_o,
    output logic [ID_W-1:0]     irq_id_o
);
    cfg_t             cfg_d, cfg_q;
    logic [NPINS-1:0] clr;
    logic [NPINS-1:0] cur, prev, pend, act;
    logic [AW-1:0]    base;
    logic             bank;
    logic [NBANKS-1:0] b_hit;
    logic [BIDX_W-1:0] b_idx [NBANKS];

    function automatic logic [NPINS-1:0] put_word(logic [NPINS-1:0] v, logic b,
                                                  logic [DW-1:0] w);
        logic [NPINS-1:0] m;
        m = {{(NPINS-DW){1'b0}}, {DW{1'b1}}} << (b ? BANK_W : 0);
        return (v & ~m) | ((NPINS'(w)) << (b ? BANK_W : 0));
    endfunction

    function automatic logic [DW-1:0] get_word(logic [NPINS-1:0] v, logic b);
        return DW'(v >> (b ? BANK_W : 0));
    endfunction

    assign base = {bus_addr_i[AW-1:2], 2'b00};
    assign bank = bus_addr_i[1];

    // next-state of the configuration words and the clear strobe
    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        if (bus_we_i) begin
            unique case (base)
                A_PEND:  clr        = put_word('0, bank, bus_wdata_i);
                A_EN:    cfg_d.en   = put_word(cfg_q.en,   bank, bus_wdata_i);
                A_MODE:  cfg_d.mode = put_word(cfg_q.mode, bank, bus_wdata_i);
                A_POL:   cfg_d.pol  = put_word(cfg_q.pol,  bank, bus_wdata_i);
                A_HOLD:  cfg_d.hold = put_word(cfg_q.hold, bank, bus_wdata_i);
                A_FSEL:  cfg_d.fsel = put_word(cfg_q.fsel, bank, bus_wdata_i);
                A_RSEL:  cfg_d.rsel = put_word(cfg_q.rsel, bank, bus_wdata_i);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    always_comb begin
        unique case (base)
            A_PEND:  bus_rdata_o = get_word(pend,       bank);
            A_EN:    bus_rdata_o = get_word(cfg_q.en,   bank);
            A_MODE:  bus_rdata_o = get_word(cfg_q.mode, bank);
            A_POL:   bus_rdata_o = get_word(cfg_q.pol,  bank);
            A_HOLD:  bus_rdata_o = get_word(cfg_q.hold, bank);
            A_FSEL:  bus_rdata_o = get_word(cfg_q.fsel, bank);
            A_RSEL:  bus_rdata_o = get_word(cfg_q.rsel, bank);
            default: bus_rdata_o = '0;
        endcase
    end

    gidc_sync #(.W(NPINS)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    gidc_detect #(.W(NPINS)) u_detect (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cur_i  (cur),
        .prev_i (prev),
        .mode_i (cfg_q.mode),
        .pol_i  (cfg_q.pol),
        .hold_i (cfg_q.hold),
        .fsel_i (cfg_q.fsel),
        .rsel_i (cfg_q.rsel),
        .clr_i  (clr),
        .pend_o (pend)
    );

    assign act = pend & cfg_q.en;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        gidc_prio #(.W(BANK_W), .IW(BIDX_W)) u_prio (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .req_i  (act[b*BANK_W +: BANK_W]),
            .hit_o  (b_hit[b]),
            .idx_o  (b_idx[b])
        );
    end

    // lower bank number overrides higher
    always_comb begin
        irq_o    = |b_hit;
        irq_id_o = '0;
        for (int b = NBANKS - 1; b >= 0; b--) begin
            if (b_hit[b]) irq_id_o = ID_W'(b * BANK_W) + ID_W'(b_idx[b]);
        end
    end

    // R9: nothing enabled means no request
    p_masked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.en == '0) |-> !irq_o);

    // R10: any low-bank request keeps the winner in the low bank
    p_low_bank_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act[BANK_W-1:0] != '0) |-> (irq_o && irq_id_o < ID_W'(BANK_W)));
endmodule

// File: tb/gpio_irq_detect_tb_top.sv
module gpio_irq_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic [4:0]  id;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R2";

    // reference model state
    logic [31:0] m_h1, m_h2, m_h3, m_pend;
    logic [31:0] m_en, m_mode, m_pol, m_hold, m_fsel, m_rsel;

    always #4 clk = ~clk;

    gpio_irq_detect dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pins),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .irq_id_o    (id)
    );

    task automatic model_reset();
        m_h1 = '0; m_h2 = '0; m_h3 = '0; m_pend = '0;
        m_en = '0; m_mode = '0; m_pol = '0; m_hold = '0; m_fsel = '0; m_rsel = '0;
    endtask

    task automatic model_tick();
        logic [31:0] nxt;
        logic [31:0] wmask;
        logic [31:0] wval;
        logic [31:0] clrv;
        for (int i = 0; i < 32; i++) begin
            bit rose, fell, hit;
            rose = m_h2[i] && !m_h3[i];
            fell = !m_h2[i] && m_h3[i];
            hit  = (rose && m_rsel[i]) || (fell && m_fsel[i]);
            clrv[i] = 1'b0;
            if (!m_mode[i])      nxt[i] = (m_h2[i] == m_pol[i]);
            else if (m_hold[i])  nxt[i] = m_pend[i];
            else                 nxt[i] = hit;
            if (m_mode[i] && m_hold[i] && hit) nxt[i] = 1'b1;
        end
        wmask = addr[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
        wval  = addr[1] ? {wdata, 16'h0} : {16'h0, wdata};
        if (we) begin
            case ({addr[5:2], 2'b00})
                6'h08: clrv = wval;
                6'h0C: m_en   = (m_en   & ~wmask) | wval;
                6'h10: m_mode = (m_mode & ~wmask) | wval;
                6'h14: m_pol  = (m_pol  & ~wmask) | wval;
                6'h18: m_hold = (m_hold & ~wmask) | wval;
                6'h20: m_fsel = (m_fsel & ~wmask) | wval;
                6'h24: m_rsel = (m_rsel & ~wmask) | wval;
                default: ;
            endcase
        end
        // a clear only lowers a held flag that had no event this cycle
        for (int i = 0; i < 32; i++) begin
            if (clrv[i] && old_mode_hold(i) && !old_hit(i)) nxt[i] = 1'b0;
        end
        m_h3 = m_h2; m_h2 = m_h1; m_h1 = pins;
        m_pend = nxt;
    endtask

    // helpers use the pre-write configuration captured before tick
    logic [31:0] o_mode, o_hold, o_hit;
    function automatic bit old_mode_hold(int i);
        return o_mode[i] && o_hold[i];
    endfunction
    function automatic bit old_hit(int i);
        return o_hit[i];
    endfunction

    task automatic capture_old();
        o_mode = m_mode;
        o_hold = m_hold;
        for (int i = 0; i < 32; i++)
            o_hit[i] = (m_h2[i] && !m_h3[i] && m_rsel[i]) || (!m_h2[i] && m_h3[i] && m_fsel[i]);
    endtask

    function automatic logic [15:0] model_read();
        logic [31:0] v;
        case ({addr[5:2], 2'b00})
            6'h08: v = m_pend;
            6'h0C: v = m_en;
            6'h10: v = m_mode;
            6'h14: v = m_pol;
            6'h18: v = m_hold;
            6'h20: v = m_fsel;
            6'h24: v = m_rsel;
            default: v = '0;
        endcase
        return addr[1] ? v[31:16] : v[15:0];
    endfunction

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", cur_req, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        logic [31:0] a;
        logic [4:0]  e_id;
        a = m_pend & m_en;
        e_id = '0;
        if (a[15:0] != 0) begin
            for (int i = 15; i >= 0; i--) if (a[i]) e_id = 5'(i);
        end else begin
            for (int i = 31; i >= 16; i--) if (a[i]) e_id = 5'(i);
        end
        cmp("irq", 32'(irq), 32'(|a));
        cmp("id", 32'(id), 32'(e_id));
        cmp("rdata", 32'(rdata), 32'(model_read()));
    endtask

    task automatic step();
        @(posedge clk);
        cyc++;
        if (!rst_n) model_reset();
        else begin
            capture_old();
            model_tick();
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(logic [5:0] a, logic [15:0] d);
        addr = a; wdata = d; we = 1'b1;
        step();
        we = 1'b0;
    endtask

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 20000) begin
                n_bad++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        model_reset();
        steps(3);
        chk("R2", "irq in reset", 32'(irq), 0);
        chk("R2", "id in reset", 32'(id), 0);
        rst_n = 1'b1;
        addr = 6'h0C;
        step();
        chk("R2", "enable after reset", 32'(rdata), 0);
        addr = 6'h14;
        step();
        chk("R2", "polarity after reset", 32'(rdata), 0);

        // R1: register map readback
        cur_req = "R1";
        wr(6'h0C, 16'hA5A5);
        wr(6'h0E, 16'h5A5A);
        addr = 6'h0C; step();
        chk("R1", "enable low", 32'(rdata), 32'hA5A5);
        addr = 6'h0E; step();
        chk("R1", "enable high", 32'(rdata), 32'h5A5A);
        wr(6'h24, 16'h1234);
        addr = 6'h24; step();
        chk("R1", "rise select low", 32'(rdata), 32'h1234);
        addr = 6'h00; step();
        chk("R1", "unmapped 0x00", 32'(rdata), 0);
        addr = 6'h1C; step();
        chk("R1", "unmapped 0x1C", 32'(rdata), 0);
        wr(6'h24, 16'h0000);
        wr(6'h0C, 16'h0000);
        wr(6'h0E, 16'h0000);

        // R4: level mode, pin 5 active high, rest active low
        cur_req = "R4";
        wr(6'h14, 16'h0020);
        pins = 32'hFFFF_FFDF;
        wr(6'h0C, 16'hFFFF);
        steps(3);
        chk("R4", "no active level", 32'(irq), 0);
        pins[5] = 1'b1;
        steps(3);
        chk("R4", "pin5 high active", 32'(id), 5);
        wr(6'h08, 16'h0020);
        chk("R4", "clear has no lasting effect", 32'(irq), 1);
        pins[2] = 1'b0;
        steps(3);
        chk("R4", "pin2 low active", 32'(id), 2);
        pins[5] = 1'b0; pins[2] = 1'b1;
        steps(3);
        chk("R4", "levels released", 32'(irq), 0);

        // R5/R6: edge mode with hold
        cur_req = "R5";
        wr(6'h10, 16'hFFFF); wr(6'h12, 16'hFFFF);
        wr(6'h18, 16'hFFFF); wr(6'h1A, 16'hFFFF);
        wr(6'h24, 16'h0080); wr(6'h20, 16'h0200);
        wr(6'h26, 16'h0010); wr(6'h22, 16'h0010);
        pins = '0;
        steps(4);
        wr(6'h08, 16'hFFFF); wr(6'h0A, 16'hFFFF);
        wr(6'h0E, 16'hFFFF);
        addr = 6'h08;
        step();
        chk("R6", "all cleared", 32'(irq), 0);
        pins[7] = 1'b1;
        steps(3);
        chk("R5", "rising pin7", 32'(id), 7);
        cur_req = "R6";
        steps(5);
        chk("R6", "pin7 sticky", 32'(id), 7);
        pins[7] = 1'b0;
        steps(3);
        chk("R6", "falling unselected keeps flag", 32'(id), 7);
        wr(6'h08, 16'h0000);
        chk("R6", "zero write keeps flag", 32'(id), 7);
        wr(6'h08, 16'h0080);
        chk("R6", "one write clears flag", 32'(irq), 0);
        cur_req = "R5";
        pins[9] = 1'b1;
        steps(3);
        chk("R5", "rise of fall-only pin9", 32'(irq), 0);
        pins[9] = 1'b0;
        steps(3);
        chk("R5", "fall of pin9", 32'(id), 9);
        cur_req = "R10";
        pins[20] = 1'b1;
        steps(3);
        chk("R10", "low bank beats pin20", 32'(id), 9);
        wr(6'h08, 16'h0200);
        chk("R10", "high bank after low cleared", 32'(id), 20);
        wr(6'h0A, 16'h0010);
        chk("R6", "high flag cleared", 32'(irq), 0);
        cur_req = "R5";
        pins[20] = 1'b0;
        steps(3);
        chk("R5", "both-edge pin20 fall", 32'(id), 20);
        wr(6'h0A, 16'h0010);

        // R8: event and clear in the same cycle
        cur_req = "R8";
        pins[7] = 1'b1;
        steps(2);
        wr(6'h08, 16'h0080);
        chk("R8", "set beats clear", 32'(id), 7);
        wr(6'h08, 16'h0080);
        chk("R8", "later clear", 32'(irq), 0);

        // R10 within a bank, R11 live read
        cur_req = "R10";
        wr(6'h24, 16'h008A);
        addr = 6'h08;
        pins[3] = 1'b1; pins[1] = 1'b1;
        steps(3);
        chk("R10", "lowest pin wins", 32'(id), 1);
        chk("R11", "pending word", 32'(rdata), 32'h000A);

        // R7: pass-through on pin 15
        cur_req = "R7";
        wr(6'h18, 16'h7FFF);
        wr(6'h24, 16'h808A);
        wr(6'h08, 16'hFFFF);
        pins[15] = 1'b1;
        steps(3);
        chk("R7", "pulse visible", 32'(id), 15);
        step();
        chk("R7", "pulse gone", 32'(irq), 0);

        // R9: enable gating, R11 flags visible while masked
        cur_req = "R9";
        pins[3] = 1'b0;
        steps(2);
        pins[3] = 1'b1;
        steps(3);
        chk("R9", "pin3 pending", 32'(id), 3);
        wr(6'h0C, 16'h0000);
        chk("R9", "masked", 32'(irq), 0);
        addr = 6'h08; step();
        chk("R11", "masked flag readable", 32'(rdata[3]), 1);
        wr(6'h0C, 16'h0008);
        chk("R9", "unmasked", 32'(id), 3);

        // R3: latency of two edges
        cur_req = "R3";
        wr(6'h0C, 16'hFFFF);
        pins[1] = 1'b0;
        steps(3);
        wr(6'h08, 16'hFFFF);
        addr = 6'h08;
        pins[1] = 1'b1;
        steps(2);
        chk("R3", "not yet after two edges", 32'(irq), 0);
        step();
        chk("R3", "seen after third edge", 32'(id), 1);

        finish_run();
    end
endmodule